// File: doc/BRIEF.md
# Oversampled Asynchronous Character Receiver

This block turns a single idle-high serial line into parallel characters. A clock enable that pulses sixteen times per bit period paces it. It qualifies each falling edge as a genuine start bit or rejects it as noise. It then samples the configured number of data bits at their bit centres, least significant first. A parity bit follows when parity is enabled, and then a single stop bit. Every finished character leaves the block as a byte with three flags (parity error, framing error, break) and a single-cycle write strobe. The strobe feeds a downstream character buffer.

Line breaks get their own handling. A line held low for a whole character yields one all-zero character flagged as a break. After that, the receiver ignores the line until it has been high for half a bit. A break that begins partway through a character first yields the damaged character with a framing error. If the line is still low half a bit after the stop sample, the receiver treats that point as a new start. The following all-low character is then reported as the break. The same re-start path lets a receiver that has lost sync recover on a character whose stop bit was low.

Character length and parity mode are static configuration inputs. A receiver-enable input holds the block idle.

Top module: `serial_rx`

## Requirements
- R1: A start bit is accepted only if the synchronised line reads low on eight consecutive oversampling ticks, counting the tick that saw the high-to-low transition. A high reading among them abandons the start, produces no strobe, and returns the receiver to edge hunting.
- R2: Data bits are taken least significant first, one per sixteen ticks, at the bit centre. `cfg_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Output bits above the configured length are zero.
- R3: `cfg_par` code 0 means no parity bit and code 1 means even parity. Code 2 means odd parity, and code 3 means the parity bit must be 1. With parity enabled, `chr_perr` is 1 exactly when the received parity bit differs from the expected one.
- R4: With a high stop bit, the character is delivered with `chr_ferr` and `chr_brk` at 0. The receiver hunts again at once, so frames sent back to back with no idle gap are all received.
- R5: A character that is not all-low but whose stop bit reads low is delivered with its data intact and `chr_ferr` at 1.
- R6: After a framing error, if the line is still low half a bit after the stop sample, that point is taken as a detected start edge. The following character is then received without needing a new falling edge.
- R7: If the start bit, the data bits, the parity bit (when enabled) and the stop bit all read low, exactly one character is delivered. It has data 0, `chr_brk` at 1, and `chr_ferr` and `chr_perr` at 0.
- R8: After a break, the line must read high on eight consecutive ticks before edge hunting resumes. A shorter high pulse followed by low produces no character.
- R9: If a break begins partway through a character, that damaged character is delivered first with `chr_ferr` at 1. An all-zero break character follows if the line stays low for the next character time.
- R10: While `rx_en` is low, the receiver stays in edge hunting and produces no strobe.
- R11: `chr_stb` is high for a single clock per character, and the data and flags are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low holds the receiver idle |
| tick | input | 1 | Oversampling enable, OVS pulses per bit period |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 forced one |
| chr_stb | output | 1 | One-cycle character write strobe |
| chr_data | output | DW | Received character, unused upper bits zero |
| chr_perr | output | 1 | Parity error flag for this character |
| chr_ferr | output | 1 | Framing error flag for this character |
| chr_brk | output | 1 | Break flag for this character |

## Verification
The assertions check four properties on every cycle. The strobe lasts a single cycle. A break character carries zero data with no other flag. Bits above the configured length are clear. No strobe appears while the receiver is disabled. Bit order, parity computation for each mode, rejection of short false starts, the half-bit re-start after a framing error, the damaged-character-then-break sequence and the half-bit high wait after a break all depend on line history spanning many bit periods. Only the bench's scenarios can show these, by comparing the delivered characters with values computed from the transmitted frames.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_ONE  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK_IDLE,
        ST_FERR_CHK
    } rx_state_e;

    typedef struct packed {
        logic perr;
        logic ferr;
        logic brk;
    } rx_flags_t;

    // Expected parity bit given the XOR of the received data bits.
    function automatic logic par_expect(par_mode_e mode, logic data_xor);
        case (mode)
            PAR_EVEN: return data_xor;
            PAR_ODD:  return ~data_xor;
            PAR_ONE:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_core.sv
module rx_frame_core
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_en,
    input  logic            tick,
    input  logic            rxd_s,
    input  logic [1:0]      cfg_len,
    input  par_mode_e       cfg_par,
    output logic            out_stb,
    output logic [DW-1:0]   out_data,
    output rx_flags_t       out_flags
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic [DW-1:0] sr;
    logic          pbit;
    logic          prev;

    logic [BW-1:0] last_idx;
    logic          at_center;
    logic          exp_p;
    logic          all_low;
    logic          perr_now;

    assign last_idx  = BW'(DW - 4 + int'(cfg_len));
    assign at_center = (cnt == CNT_LAST);
    assign exp_p     = par_expect(cfg_par, ^sr);
    assign all_low   = (sr == '0) && !rxd_s && ((cfg_par == PAR_NONE) || !pbit);
    assign perr_now  = (cfg_par != PAR_NONE) && (pbit != exp_p);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            cnt       <= '0;
            bidx      <= '0;
            sr        <= '0;
            pbit      <= 1'b0;
            prev      <= 1'b0;
            out_stb   <= 1'b0;
            out_data  <= '0;
            out_flags <= '0;
        end else begin
            out_stb <= 1'b0;
            if (!rx_en) begin
                state <= ST_HUNT;
                prev  <= 1'b0;
                cnt   <= '0;
            end else if (tick) begin
                case (state)
                    ST_HUNT: begin
                        prev <= rxd_s;
                        if (prev && !rxd_s) begin
                            state <= ST_START;
                            cnt   <= CW'(1);
                        end
                    end
                    ST_START: begin
                        if (rxd_s) begin
                            state <= ST_HUNT;
                            prev  <= 1'b1;
                        end else if (cnt == CNT_HALF) begin
                            state <= ST_DATA;
                            cnt   <= '0;
                            bidx  <= '0;
                            sr    <= '0;
                            pbit  <= 1'b0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_center) begin
                            cnt      <= '0;
                            sr[bidx] <= rxd_s;
                            if (bidx == last_idx)
                                state <= (cfg_par == PAR_NONE) ? ST_STOP : ST_PAR;
                            else
                                bidx <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_center) begin
                            cnt   <= '0;
                            pbit  <= rxd_s;
                            state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_center) begin
                            cnt     <= '0;
                            out_stb <= 1'b1;
                            if (all_low) begin
                                out_data  <= '0;
                                out_flags <= '{perr: 1'b0, ferr: 1'b0, brk: 1'b1};
                                state     <= ST_BRK_IDLE;
                            end else begin
                                out_data  <= sr;
                                out_flags <= '{perr: perr_now, ferr: !rxd_s, brk: 1'b0};
                                if (rxd_s) begin
                                    state <= ST_HUNT;
                                    prev  <= 1'b1;
                                end else begin
                                    state <= ST_FERR_CHK;
                                end
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BRK_IDLE: begin
                        if (!rxd_s) begin
                            cnt <= '0;
                        end else if (cnt == CNT_HALF) begin
                            state <= ST_HUNT;
                            prev  <= 1'b1;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_FERR_CHK: begin
                        if (cnt == CNT_HALF) begin
                            if (!rxd_s) begin
                                state <= ST_START;
                                cnt   <= CW'(1);
                            end else begin
                                state <= ST_HUNT;
                                prev  <= 1'b1;
                                cnt   <= '0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int DW        = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          tick,
    input  logic          rxd,
    input  logic [1:0]    cfg_len,
    input  logic [1:0]    cfg_par,
    output logic          chr_stb,
    output logic [DW-1:0] chr_data,
    output logic          chr_perr,
    output logic          chr_ferr,
    output logic          chr_brk
);
    logic      rxd_s;
    rx_flags_t flags;

    rx_line_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rxd_s)
    );

    rx_frame_core #(.OVS(OVS), .DW(DW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .tick      (tick),
        .rxd_s     (rxd_s),
        .cfg_len   (cfg_len),
        .cfg_par   (par_mode_e'(cfg_par)),
        .out_stb   (chr_stb),
        .out_data  (chr_data),
        .out_flags (flags)
    );

    assign chr_perr = flags.perr;
    assign chr_ferr = flags.ferr;
    assign chr_brk  = flags.brk;
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_en,
    input logic [1:0]    cfg_len,
    input logic          chr_stb,
    input logic [DW-1:0] chr_data,
    input logic          chr_perr,
    input logic          chr_ferr,
    input logic          chr_brk
);
    logic [DW-1:0] len_mask;
    assign len_mask = {DW{1'b1}} >> (3 - int'(cfg_len));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        chr_stb |=> !chr_stb);

    a_r7_break_clean: assert property (@(posedge clk) disable iff (rst)
        (chr_stb && chr_brk) |-> (chr_data == '0 && !chr_ferr && !chr_perr));

    a_r2_upper_clear: assert property (@(posedge clk) disable iff (rst)
        chr_stb |-> ((chr_data & ~len_mask) == '0));

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !chr_stb);
endmodule

bind serial_rx serial_rx_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .cfg_len  (cfg_len),
    .chr_stb  (chr_stb),
    .chr_data (chr_data),
    .chr_perr (chr_perr),
    .chr_ferr (chr_ferr),
    .chr_brk  (chr_brk)
);

// File: tb/tb_serial_rx.sv
module tb_serial_rx;
    localparam int OVS    = 16;
    localparam int DW     = 8;
    localparam int TDIV   = 2;
    localparam int BITCLK = OVS * TDIV;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_en = 1'b0;
    logic          tick = 1'b0;
    logic          rxd = 1'b1;
    logic [1:0]    cfg_len = 2'd3;
    logic [1:0]    cfg_par = 2'd0;
    logic          chr_stb;
    logic [DW-1:0] chr_data;
    logic          chr_perr, chr_ferr, chr_brk;

    int n_tests = 0;
    int n_fail  = 0;
    int n_got   = 0;
    int cap [0:7];

    serial_rx #(.OVS(OVS), .DW(DW)) dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .tick(tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par),
        .chr_stb(chr_stb), .chr_data(chr_data),
        .chr_perr(chr_perr), .chr_ferr(chr_ferr), .chr_brk(chr_brk)
    );

    always #10 clk = ~clk;

    always @(posedge clk) tick <= ~tick;

    always @(negedge clk) begin
        if (chr_stb) begin
            if (n_got < 8) cap[n_got] = {21'd0, chr_perr, chr_ferr, chr_brk, chr_data};
            n_got = n_got + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pack(bit pe, bit fe, bit bk, logic [7:0] d);
        return {21'd0, pe, fe, bk, d};
    endfunction

    task automatic line(bit v, int clks);
        rxd = v;
        repeat (clks) @(negedge clk);
    endtask

    function automatic logic [7:0] lmask(int lc);
        return 8'hFF >> (3 - lc);
    endfunction

    task automatic send(logic [7:0] d, int lc, int pm, bit flip, bit stopv);
        logic [7:0] m;
        bit p;
        m = d & lmask(lc);
        line(1'b0, BITCLK);
        for (int i = 0; i < 5 + lc; i++) line(d[i], BITCLK);
        if (pm != 0) begin
            p = (pm == 1) ? ^m : (pm == 2) ? ~^m : 1'b1;
            line(p ^ flip, BITCLK);
        end
        line(stopv, BITCLK);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] vals [0:5];
        vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'hA5;
        vals[3] = 8'h5A; vals[4] = 8'h01; vals[5] = 8'h96;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset strobe low", int'(chr_stb), 0);
        rx_en = 1'b1;
        line(1'b1, 2 * BITCLK);

        // R2 R3 R4: sweep of length, parity mode, data and parity corruption
        for (int lc = 0; lc < 4; lc++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int f = 0; f < 2; f++) begin
                    if (pm == 0 && f == 1) continue;
                    for (int v = 0; v < 6; v++) begin
                        cfg_len = 2'(lc);
                        cfg_par = 2'(pm);
                        n_got = 0;
                        send(vals[v], lc, pm, f[0], 1'b1);
                        line(1'b1, BITCLK);
                        chk("R2 R4 count", n_got, 1);
                        chk("R2 R3 char", cap[0], pack(f[0], 1'b0, 1'b0, vals[v] & lmask(lc)));
                    end
                end
            end
        end

        cfg_len = 2'd3;
        cfg_par = 2'd0;

        // R4: back-to-back frames without idle gap
        n_got = 0;
        send(8'h12, 3, 0, 1'b0, 1'b1);
        send(8'h34, 3, 0, 1'b0, 1'b1);
        line(1'b1, BITCLK);
        chk("R4 back-to-back count", n_got, 2);
        chk("R4 first", cap[0], pack(0, 0, 0, 8'h12));
        chk("R4 second", cap[1], pack(0, 0, 0, 8'h34));

        // R1: short low glitch is no start
        n_got = 0;
        line(1'b0, 3 * TDIV);
        line(1'b1, 2 * BITCLK);
        chk("R1 false start", n_got, 0);
        send(8'hC3, 3, 0, 1'b0, 1'b1);
        line(1'b1, BITCLK);
        chk("R1 after false start", cap[0], pack(0, 0, 0, 8'hC3));

        // R5: framing error, line returns high
        n_got = 0;
        send(8'h55, 3, 0, 1'b0, 1'b0);
        line(1'b1, 2 * BITCLK);
        chk("R5 count", n_got, 1);
        chk("R5 ferr char", cap[0], pack(0, 1, 0, 8'h55));

        // R6: low stop followed at once by a start with no falling edge
        n_got = 0;
        send(8'h55, 3, 0, 1'b0, 1'b0);
        send(8'h3C, 3, 0, 1'b0, 1'b1);
        line(1'b1, 2 * BITCLK);
        chk("R6 count", n_got, 2);
        chk("R6 damaged", cap[0], pack(0, 1, 0, 8'h55));
        chk("R6 resync", cap[1], pack(0, 0, 0, 8'h3C));

        // R7: full-character break with odd parity enabled
        cfg_par = 2'd2;
        n_got = 0;
        line(1'b0, 14 * BITCLK);
        line(1'b1, 2 * BITCLK);
        chk("R7 count", n_got, 1);
        chk("R7 break char", cap[0], pack(0, 0, 1, 8'h00));
        cfg_par = 2'd0;

        // R8: short high pulse after a break starts nothing
        n_got = 0;
        line(1'b0, 12 * BITCLK);
        line(1'b1, 2 * TDIV);
        line(1'b0, BITCLK);
        line(1'b1, 3 * BITCLK);
        chk("R8 blip ignored", n_got, 1);
        chk("R8 break char", cap[0], pack(0, 0, 1, 8'h00));
        send(8'h81, 3, 0, 1'b0, 1'b1);
        line(1'b1, BITCLK);
        chk("R8 hunting resumed", cap[1], pack(0, 0, 0, 8'h81));

        // R9: break begins after four high data bits
        n_got = 0;
        line(1'b0, BITCLK);
        for (int i = 0; i < 4; i++) line(1'b1, BITCLK);
        line(1'b0, 25 * BITCLK);
        line(1'b1, 3 * BITCLK);
        chk("R9 count", n_got, 2);
        chk("R9 damaged", cap[0], pack(0, 1, 0, 8'h0F));
        chk("R9 break", cap[1], pack(0, 0, 1, 8'h00));

        // R10: disabled receiver ignores a frame
        rx_en = 1'b0;
        n_got = 0;
        send(8'h5A, 3, 0, 1'b0, 1'b1);
        line(1'b1, BITCLK);
        chk("R10 disabled", n_got, 0);
        rx_en = 1'b1;
        line(1'b1, BITCLK);
        send(8'h5A, 3, 0, 1'b0, 1'b1);
        line(1'b1, BITCLK);
        chk("R10 re-enabled", cap[0], pack(0, 0, 0, 8'h5A));
        chk("R11 one strobe per char", n_got, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule